// File: doc/BRIEF.md
# OTG ID/VBUS Detection Controller

This block manages the dual-role port of a USB PHY. It reads a cable ID pin and a VBUS-present input. It resolves them against a port mode select (host, peripheral or dual-role) into an effective role and an effective VBUS state. It then writes the results as forced ID and VBUS override fields into a status register image that sits beside the PHY. Changes on the pins are not acted on at once. The block waits a settle time, counted in ticks of an external millisecond strobe, and only then scans the inputs. An optional periodic rescan covers inputs that cannot raise an event.

A role change may need a session end. This happens on a mode change, or in dual-role mode when no VBUS sensing exists. The block then produces a timed VBUS-low pulse in the override field. The pulse is short and comes before the ID update when the port becomes host. It is long and comes after the ID update when the port leaves host. The block also drives a controller routing select, a host-path bypass enable and one-cycle change strobes for ID and VBUS. Nothing is scanned while the PHY-initialized flag is low.

Top module: `otg_detect_ctrl`

## Requirements
- R1: After reset, the status image is all zero, `route_periph`, `host_bypass`, `id_change` and `vbus_change` are 0, and both override fields read 2'b00 (not forcing).
- R2: Bits 17 (ID pull-up) and 16 (D+/D- pull-up) of the status image are both 1 while `phy_init` is high and both 0 while it is low. Dropping `phy_init` also clears `host_bypass`.
- R3: The override fields are ID at bits 15:14 and VBUS at bits 13:12, with 2'b10 = forced low and 2'b11 = forced high. When `phy_init` rises, the stored ID and VBUS are invalidated. The first scan follows within a few cycles, with no settle wait, and writes both fields and pulses both `id_change` and `vbus_change`.
- R4: The effective ID depends on `mode`: 2'b10 (host) gives 0, 2'b11 (dual-role) gives `id_pin` if `id_pin_present` else 1, and 2'b01 or 2'b00 (peripheral) gives 1.
- R5: The effective VBUS is `vbus_in` when `vbus_present` is 1, else 1.
- R6: An edge on a present ID or VBUS pin starts a settle window of SETTLE_MS ticks (default 50, at most 100). The scan happens when the window expires, and a further edge restarts the window.
- R7: While `poll_en` is high and no other work is pending, the inputs are rescanned every POLL_MS ticks (default 250).
- R8: When a session end is forced and the new ID is 0, the VBUS field is forced low for ENTRY_MS ticks (default 200) and then high. The ID field and `id_change` update only after that.
- R9: When a session end is forced and the new ID is 1, the ID field and `id_change` update first. The VBUS field is then forced low for EXIT_MS ticks (default 1000) and then high.
- R10: In dual-role mode with `vbus_present` low, an ID change forces a session end. With `vbus_present` high it does not, and the VBUS field keeps its value.
- R11: A change of `mode` while initialized invalidates the stored ID, forces a session end and starts a scan without the settle wait.
- R12: After each ID update, `host_bypass` is the inverse of the ID. With DUAL_ROUTE set, `route_periph` equals the ID (0 = host path, 1 = peripheral path).
- R13: While `phy_init` is low, no scan happens: the fields stay put and no change strobe fires. Each change strobe is exactly one cycle wide and fires only when its value changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| phy_init | input | 1 | PHY initialized flag |
| mode | input | 2 | Port mode: 01/00 peripheral, 10 host, 11 dual-role |
| id_pin | input | 1 | Cable ID level |
| id_pin_present | input | 1 | An ID pin is wired |
| vbus_in | input | 1 | VBUS sense level |
| vbus_present | input | 1 | VBUS sensing is wired |
| poll_en | input | 1 | Periodic rescan required |
| status_img | output | REG_W | Interface status register image |
| route_periph | output | 1 | Controller routing: 1 peripheral, 0 host |
| host_bypass | output | 1 | Host-path bypass enable |
| id_change | output | 1 | One-cycle strobe on ID field update |
| vbus_change | output | 1 | One-cycle strobe on VBUS field update |

## Verification
The bench probes each timing window on both sides: just before and just after the settle time, the periodic rescan, and the entry and exit pulses. A design with the wrong window length, or one that fails to restart the settle window on a second edge, fails at one of these points. It checks the order of the two session-end pulses against the ID field. A design that updates ID before the entry pulse, or after the exit pulse, shows the wrong ID while VBUS is still low. It checks that the first scan after init reports both fields even though the values match the previous state. It checks that dual-role mode with VBUS sensing never drops VBUS. It checks that a mode change causes an exit pulse even when the ID value does not change.

// File: rtl/otg_det_pkg.sv
package otg_det_pkg;

   localparam logic [1:0] MODE_PERIPH = 2'b01;
   localparam logic [1:0] MODE_HOST   = 2'b10;
   localparam logic [1:0] MODE_DUAL   = 2'b11;

   localparam logic [1:0] FORCE_NONE = 2'b00;
   localparam logic [1:0] FORCE_LOW  = 2'b10;
   localparam logic [1:0] FORCE_HIGH = 2'b11;

   localparam int BIT_ID_PU   = 17;
   localparam int BIT_DPDM_PU = 16;
   localparam int ID_FLD_LSB  = 14;
   localparam int VB_FLD_LSB  = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SCAN,
      ST_ENTRY,
      ST_COMMIT,
      ST_EXIT
   } scan_st_e;

   function automatic logic [1:0] force_enc(input logic level);
      return level ? FORCE_HIGH : FORCE_LOW;
   endfunction

   function automatic int max_of2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/otg_ms_timer.sv
module otg_ms_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             cancel,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign done = run_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (cancel) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= 1'b1;
      end else if (done) begin
         run_q <= 1'b0;
      end else if (run_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick && !load && !cancel && !done) |=> (cnt_q == $past(cnt_q))) // R6
      else $error("timer moved without a tick");

endmodule

// File: rtl/otg_eff_inputs.sv
module otg_eff_inputs
   import otg_det_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       id_pin,
   input  logic       id_pin_present,
   input  logic       vbus_in,
   input  logic       vbus_present,
   output logic       eff_id,
   output logic       eff_vbus,
   output logic       dual_mode,
   output logic       pin_evt,
   output logic       mode_evt
);

   logic       id_q;
   logic       vb_q;
   logic [1:0] mode_q;

   always_comb begin
      unique case (mode)
         MODE_HOST: eff_id = 1'b0;
         MODE_DUAL: eff_id = id_pin_present ? id_pin : 1'b1;
         default:   eff_id = 1'b1;
      endcase
   end

   assign eff_vbus  = vbus_present ? vbus_in : 1'b1;
   assign dual_mode = (mode == MODE_DUAL);
   assign pin_evt   = (id_pin_present && (id_pin != id_q)) ||
                      (vbus_present && (vbus_in != vb_q));
   assign mode_evt  = (mode != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q   <= 1'b1;
         vb_q   <= 1'b0;
         mode_q <= MODE_PERIPH;
      end else begin
         id_q   <= id_pin;
         vb_q   <= vbus_in;
         mode_q <= mode;
      end
   end

   AST_HOST_ID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOST) |-> !eff_id) // R4
      else $error("host mode without ID low");

endmodule

// File: rtl/otg_scan_fsm.sv
module otg_scan_fsm
   import otg_det_pkg::*;
#(
   parameter int SETTLE_MS = 50,
   parameter int POLL_MS   = 250,
   parameter int ENTRY_MS  = 200,
   parameter int EXIT_MS   = 1000,
   parameter int CNT_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phy_init,
   input  logic             pin_evt,
   input  logic             mode_evt,
   input  logic             dual_mode,
   input  logic             vbus_sense,
   input  logic             eff_id,
   input  logic             eff_vbus,
   input  logic             poll_en,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             tmr_cancel,
   output logic [1:0]       id_field,
   output logic [1:0]       vbus_field,
   output logic             id_pulse,
   output logic             vbus_pulse,
   output logic             host_bypass,
   output logic             route_id
);

   localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE_MS);
   localparam logic [CNT_W-1:0] POLL_V   = CNT_W'(POLL_MS);
   localparam logic [CNT_W-1:0] ENTRY_V  = CNT_W'(ENTRY_MS);
   localparam logic [CNT_W-1:0] EXIT_V   = CNT_W'(EXIT_MS);

   scan_st_e st_q, st_n;
   logic init_q, init_rise, busy;
   logic id_q, id_valid, vb_q, vb_valid;
   logic fse_pend, pend_scan, pend_settle;
   logic sc_id, sc_vbus, sc_idchg, sc_vbchg, sc_fse;
   logic scan_idchg, scan_vbchg, scan_fse;

   assign init_rise  = phy_init && !init_q;
   assign busy       = (st_q == ST_SCAN) || (st_q == ST_ENTRY) ||
                       (st_q == ST_COMMIT) || (st_q == ST_EXIT);
   assign scan_idchg = !id_valid || (eff_id != id_q);
   assign scan_vbchg = !vb_valid || (eff_vbus != vb_q);
   assign scan_fse   = fse_pend || (dual_mode && !vbus_sense && scan_idchg);
   assign tmr_cancel = !phy_init;

   always_comb begin
      st_n     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (!phy_init) begin
         st_n = ST_IDLE;
      end else if (init_rise) begin
         st_n = ST_SCAN;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (pend_scan || mode_evt) begin
                  st_n = ST_SCAN;
               end else if (pend_settle || pin_evt) begin
                  st_n = ST_WAIT; tmr_load = 1'b1; tmr_val = SETTLE_V;
               end else if (poll_en) begin
                  st_n = ST_WAIT; tmr_load = 1'b1; tmr_val = POLL_V;
               end
            end
            ST_WAIT: begin
               if (mode_evt) begin
                  st_n = ST_SCAN;
               end else if (pin_evt) begin
                  tmr_load = 1'b1; tmr_val = SETTLE_V;
               end else if (tmr_done) begin
                  st_n = ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (scan_idchg && scan_fse && !eff_id) begin
                  st_n = ST_ENTRY; tmr_load = 1'b1; tmr_val = ENTRY_V;
               end else begin
                  st_n = ST_COMMIT;
               end
            end
            ST_ENTRY: if (tmr_done) st_n = ST_COMMIT;
            ST_COMMIT: begin
               if (sc_idchg && sc_fse && sc_id) begin
                  st_n = ST_EXIT; tmr_load = 1'b1; tmr_val = EXIT_V;
               end else begin
                  st_n = ST_IDLE;
               end
            end
            ST_EXIT: if (tmr_done) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         init_q      <= 1'b0;
         id_q        <= 1'b0;
         id_valid    <= 1'b0;
         vb_q        <= 1'b0;
         vb_valid    <= 1'b0;
         fse_pend    <= 1'b0;
         pend_scan   <= 1'b0;
         pend_settle <= 1'b0;
         sc_id       <= 1'b0;
         sc_vbus     <= 1'b0;
         sc_idchg    <= 1'b0;
         sc_vbchg    <= 1'b0;
         sc_fse      <= 1'b0;
         id_field    <= FORCE_NONE;
         vbus_field  <= FORCE_NONE;
         id_pulse    <= 1'b0;
         vbus_pulse  <= 1'b0;
         host_bypass <= 1'b0;
         route_id    <= 1'b0;
      end else begin
         id_pulse   <= 1'b0;
         vbus_pulse <= 1'b0;
         init_q     <= phy_init;
         if (!phy_init) begin
            st_q        <= ST_IDLE;
            fse_pend    <= 1'b0;
            pend_scan   <= 1'b0;
            pend_settle <= 1'b0;
            host_bypass <= 1'b0;
         end else begin
            st_q <= st_n;
            if (st_q == ST_IDLE) begin
               pend_scan   <= 1'b0;
               pend_settle <= 1'b0;
            end else if (busy) begin
               if (pin_evt)  pend_settle <= 1'b1;
               if (mode_evt) pend_scan   <= 1'b1;
            end
            if (init_rise) begin
               id_valid <= 1'b0;
               vb_valid <= 1'b0;
               fse_pend <= 1'b0;
            end else begin
               unique case (st_q)
                  ST_SCAN: begin
                     sc_id    <= eff_id;
                     sc_vbus  <= eff_vbus;
                     sc_idchg <= scan_idchg;
                     sc_vbchg <= scan_vbchg;
                     sc_fse   <= scan_fse;
                     fse_pend <= 1'b0;
                     if (scan_idchg && scan_fse && !eff_id) vbus_field <= FORCE_LOW;
                  end
                  ST_ENTRY: if (tmr_done) vbus_field <= FORCE_HIGH;
                  ST_COMMIT: begin
                     if (sc_idchg) begin
                        id_field    <= force_enc(sc_id);
                        id_q        <= sc_id;
                        id_valid    <= 1'b1;
                        id_pulse    <= 1'b1;
                        host_bypass <= !sc_id;
                        route_id    <= sc_id;
                     end
                     if (sc_vbchg) begin
                        vbus_field <= force_enc(sc_vbus);
                        vb_q       <= sc_vbus;
                        vb_valid   <= 1'b1;
                        vbus_pulse <= 1'b1;
                     end
                     if (sc_idchg && sc_fse && sc_id) vbus_field <= FORCE_LOW;
                  end
                  ST_EXIT: if (tmr_done) vbus_field <= FORCE_HIGH;
                  default: ;
               endcase
               if (mode_evt) begin
                  fse_pend <= 1'b1;
                  id_valid <= 1'b0;
               end
            end
         end
      end
   end

   AST_ID_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      id_pulse |=> !id_pulse) // R13
      else $error("id strobe longer than one cycle");

   AST_VBUS_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_pulse |=> !vbus_pulse) // R13
      else $error("vbus strobe longer than one cycle");

   AST_ENTRY_VBUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ENTRY) |-> (vbus_field == FORCE_LOW)) // R8
      else $error("vbus not forced low during entry pulse");

   AST_EXIT_VBUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EXIT) |-> (vbus_field == FORCE_LOW && id_field == FORCE_HIGH)) // R9
      else $error("exit pulse without ID high and VBUS low");

   AST_BYPASS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      host_bypass |-> (id_field == FORCE_LOW)) // R12
      else $error("bypass enabled outside host role");

   AST_ID_PULSE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      id_pulse |-> id_field[1]) // R3
      else $error("id strobe with unforced field");

endmodule

// File: rtl/otg_detect_ctrl.sv
module otg_detect_ctrl
   import otg_det_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int SETTLE_MS  = 50,
   parameter int POLL_MS    = 250,
   parameter int ENTRY_MS   = 200,
   parameter int EXIT_MS    = 1000,
   parameter bit DUAL_ROUTE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             phy_init,
   input  logic [1:0]       mode,
   input  logic             id_pin,
   input  logic             id_pin_present,
   input  logic             vbus_in,
   input  logic             vbus_present,
   input  logic             poll_en,
   output logic [REG_W-1:0] status_img,
   output logic             route_periph,
   output logic             host_bypass,
   output logic             id_change,
   output logic             vbus_change
);

   localparam int T_MAX = max_of2(max_of2(SETTLE_MS, POLL_MS), max_of2(ENTRY_MS, EXIT_MS));
   localparam int CNT_W = $clog2(T_MAX + 1);

   if (REG_W < BIT_ID_PU + 1) begin : g_bad_width
      $error("REG_W too small for status image");
   end
   if (SETTLE_MS < 1 || SETTLE_MS > 100) begin : g_bad_settle
      $error("SETTLE_MS must lie in 1..100");
   end
   if (POLL_MS < 1 || ENTRY_MS < 1 || EXIT_MS < 1) begin : g_bad_time
      $error("time parameters must be positive");
   end

   logic eff_id, eff_vbus, dual_mode, pin_evt, mode_evt;
   logic tmr_load, tmr_cancel, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic [1:0] id_field, vbus_field;
   logic route_id, pu_q;

   otg_eff_inputs u_inputs (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode           (mode),
      .id_pin         (id_pin),
      .id_pin_present (id_pin_present),
      .vbus_in        (vbus_in),
      .vbus_present   (vbus_present),
      .eff_id         (eff_id),
      .eff_vbus       (eff_vbus),
      .dual_mode      (dual_mode),
      .pin_evt        (pin_evt),
      .mode_evt       (mode_evt)
   );

   otg_ms_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ms_tick),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cancel   (tmr_cancel),
      .done     (tmr_done)
   );

   otg_scan_fsm #(
      .SETTLE_MS (SETTLE_MS),
      .POLL_MS   (POLL_MS),
      .ENTRY_MS  (ENTRY_MS),
      .EXIT_MS   (EXIT_MS),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .phy_init    (phy_init),
      .pin_evt     (pin_evt),
      .mode_evt    (mode_evt),
      .dual_mode   (dual_mode),
      .vbus_sense  (vbus_present),
      .eff_id      (eff_id),
      .eff_vbus    (eff_vbus),
      .poll_en     (poll_en),
      .tmr_done    (tmr_done),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .tmr_cancel  (tmr_cancel),
      .id_field    (id_field),
      .vbus_field  (vbus_field),
      .id_pulse    (id_change),
      .vbus_pulse  (vbus_change),
      .host_bypass (host_bypass),
      .route_id    (route_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pu_q <= 1'b0;
      else        pu_q <= phy_init;
   end

   always_comb begin
      status_img = '0;
      status_img[BIT_ID_PU]   = pu_q;
      status_img[BIT_DPDM_PU] = pu_q;
      status_img[ID_FLD_LSB +: 2] = id_field;
      status_img[VB_FLD_LSB +: 2] = vbus_field;
   end

   if (DUAL_ROUTE) begin : g_dual_route
      assign route_periph = route_id;
      AST_ROUTE_FOLLOWS_ID: assert property (@(posedge clk) disable iff (!rst_n)
         (id_field[1]) |-> (route_periph == id_field[0])) // R12
         else $error("routing disagrees with ID field");
   end else begin : g_single_route
      assign route_periph = 1'b0;
   end

   AST_FIELD_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
      (id_field != 2'b01) && (vbus_field != 2'b01)) // R3
      else $error("illegal override encoding");

   AST_PULLUP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      status_img[BIT_ID_PU] == status_img[BIT_DPDM_PU]) // R2
      else $error("pull-up bits disagree");

   AST_NO_STROBE_UNINIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!phy_init && !pu_q) |=> (!id_change && !vbus_change)) // R13
      else $error("change strobe while not initialized");

endmodule

// File: tb/test_otg_detect_ctrl.sv
`timescale 1ns/1ps
module test_otg_detect_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic        phy_init = 1'b0;
   logic [1:0]  mode = 2'b11;
   logic        id_pin = 1'b1;
   logic        id_pin_present = 1'b1;
   logic        vbus_in = 1'b1;
   logic        vbus_present = 1'b1;
   logic        poll_en = 1'b0;
   logic [31:0] status_img;
   logic        route_periph, host_bypass, id_change, vbus_change;

   int n_chk = 0;
   int n_err = 0;
   int id_pc = 0;
   int vb_pc = 0;
   int vlow  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   otg_detect_ctrl i_otg_detect_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .ms_tick        (ms_tick),
      .phy_init       (phy_init),
      .mode           (mode),
      .id_pin         (id_pin),
      .id_pin_present (id_pin_present),
      .vbus_in        (vbus_in),
      .vbus_present   (vbus_present),
      .poll_en        (poll_en),
      .status_img     (status_img),
      .route_periph   (route_periph),
      .host_bypass    (host_bypass),
      .id_change      (id_change),
      .vbus_change    (vbus_change)
   );

   always @(negedge clk) begin
      if (id_change) id_pc++;
      if (vbus_change) vb_pc++;
      if (status_img[13:12] == 2'b10) vlow++;
   end

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ms(input int n);
      cyc(4 * n);
   endtask

   function automatic logic [31:0] idf();
      return {30'd0, status_img[15:14]};
   endfunction

   function automatic logic [31:0] vbf();
      return {30'd0, status_img[13:12]};
   endfunction

   task automatic t_reset();
      chk("R1 image", status_img, 32'h0);
      chk("R1 route", {31'd0, route_periph}, 32'd0);
      chk("R1 bypass", {31'd0, host_bypass}, 32'd0);
      chk("R1 strobes", {30'd0, id_change, vbus_change}, 32'd0);
   endtask

   task automatic t_uninit();
      int i0 = id_pc, v0 = vb_pc;
      id_pin = 1'b0; ms(3); id_pin = 1'b1; ms(60);
      chk("R13 no id strobe uninit", id_pc - i0, 0);
      chk("R13 no vbus strobe uninit", vb_pc - v0, 0);
      chk("R13 fields untouched", status_img, 32'h0);
   endtask

   task automatic t_first_scan();
      int i0 = id_pc, v0 = vb_pc;
      phy_init = 1'b1; cyc(10);
      chk("R3 first scan image", status_img, 32'h0003_F000);
      chk("R2 pull-ups set", {30'd0, status_img[17:16]}, 32'd3);
      chk("R3 id strobe", id_pc - i0, 1);
      chk("R3 vbus strobe", vb_pc - v0, 1);
      chk("R12 route periph", {31'd0, route_periph}, 32'd1);
      chk("R12 bypass off", {31'd0, host_bypass}, 32'd0);
   endtask

   task automatic t_settle();
      int i0 = id_pc, v0 = vb_pc;
      vbus_in = 1'b0; ms(45);
      chk("R6 unchanged before settle", vbf(), 32'd3);
      chk("R6 no strobe before settle", vb_pc - v0, 0);
      ms(10);
      chk("R6 R5 vbus low after settle", vbf(), 32'd2);
      chk("R6 vbus strobe", vb_pc - v0, 1);
      chk("R13 no id strobe on vbus change", id_pc - i0, 0);
   endtask

   task automatic t_settle_restart();
      vbus_in = 1'b1; ms(30);
      vbus_in = 1'b0; ms(1); vbus_in = 1'b1;
      ms(39);
      chk("R6 restart holds field", vbf(), 32'd2);
      ms(20);
      chk("R6 restart then update", vbf(), 32'd3);
   endtask

   task automatic t_dual_sensed();
      int i0 = id_pc, l0 = vlow;
      id_pin = 1'b0; ms(60);
      chk("R10 id low no session end", idf(), 32'd2);
      chk("R10 vbus kept high", vlow - l0, 0);
      chk("R12 bypass in host", {31'd0, host_bypass}, 32'd1);
      chk("R12 route host", {31'd0, route_periph}, 32'd0);
      chk("R13 single id strobe", id_pc - i0, 1);
      id_pin = 1'b1; ms(60);
      chk("R10 id back high", idf(), 32'd3);
      chk("R10 still no vbus drop", vlow - l0, 0);
      chk("R12 route periph again", {31'd0, route_periph}, 32'd1);
   endtask

   task automatic t_entry_pulse();
      int i0;
      vbus_present = 1'b0; cyc(4);
      i0 = id_pc;
      id_pin = 1'b0; ms(60);
      chk("R8 R10 vbus low in entry", vbf(), 32'd2);
      chk("R8 id held during entry", idf(), 32'd3);
      chk("R8 no id strobe yet", id_pc - i0, 0);
      ms(180);
      chk("R8 entry still low", vbf(), 32'd2);
      ms(30);
      chk("R8 vbus high after entry", vbf(), 32'd3);
      chk("R8 id low after entry", idf(), 32'd2);
      chk("R8 id strobe after entry", id_pc - i0, 1);
   endtask

   task automatic t_exit_pulse();
      int i0 = id_pc;
      id_pin = 1'b1; ms(60);
      chk("R9 id high first", idf(), 32'd3);
      chk("R9 id strobe", id_pc - i0, 1);
      chk("R9 vbus low in exit", vbf(), 32'd2);
      ms(980);
      chk("R9 exit still low", vbf(), 32'd2);
      ms(30);
      chk("R9 vbus high after exit", vbf(), 32'd3);
   endtask

   task automatic t_mode_host();
      mode = 2'b10; cyc(10);
      chk("R11 immediate entry pulse", vbf(), 32'd2);
      chk("R11 id held", idf(), 32'd3);
      ms(210);
      chk("R4 host forces id low", idf(), 32'd2);
      chk("R11 vbus high after", vbf(), 32'd3);
      chk("R12 bypass host", {31'd0, host_bypass}, 32'd1);
      chk("R12 route host", {31'd0, route_periph}, 32'd0);
   endtask

   task automatic t_poll();
      int v0;
      vbus_in = 1'b0; cyc(4);
      vbus_present = 1'b1; v0 = vb_pc;
      poll_en = 1'b1;
      ms(240);
      chk("R7 before poll", vbf(), 32'd3);
      ms(25);
      chk("R7 poll picks vbus low", vbf(), 32'd2);
      chk("R7 poll strobe", vb_pc - v0, 1);
      poll_en = 1'b0;
   endtask

   task automatic t_reinit();
      int i0, v0;
      phy_init = 1'b0; cyc(4);
      chk("R2 pull-ups cleared", {30'd0, status_img[17:16]}, 32'd0);
      chk("R2 bypass cleared", {31'd0, host_bypass}, 32'd0);
      chk("R13 id field kept", idf(), 32'd2);
      i0 = id_pc; v0 = vb_pc;
      mode = 2'b01; ms(20);
      chk("R13 mode change uninit ignored", id_pc - i0, 0);
      phy_init = 1'b1; cyc(10);
      chk("R3 R4 reinit id high", idf(), 32'd3);
      chk("R3 R5 reinit vbus low", vbf(), 32'd2);
      chk("R3 reinit id strobe", id_pc - i0, 1);
      chk("R3 reinit vbus strobe", vb_pc - v0, 1);
      chk("R12 route periph", {31'd0, route_periph}, 32'd1);
   endtask

   task automatic t_mode_dual_exit();
      int i0;
      vbus_in = 1'b1; ms(60);
      chk("R5 vbus high", vbf(), 32'd3);
      i0 = id_pc;
      mode = 2'b11; cyc(10);
      chk("R11 id strobe on same id", id_pc - i0, 1);
      chk("R11 R9 exit pulse low", vbf(), 32'd2);
      chk("R4 dual uses pin", idf(), 32'd3);
      ms(985);
      chk("R9 exit still low", vbf(), 32'd2);
      ms(30);
      chk("R9 high after exit", vbf(), 32'd3);
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(3);
      t_reset();
      t_uninit();
      t_first_scan();
      t_settle();
      t_settle_restart();
      t_dual_sensed();
      t_entry_pulse();
      t_exit_pulse();
      t_mode_host();
      t_poll();
      t_reinit();
      t_mode_dual_exit();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule